// File: doc/BRIEF.md
# Coefficient Compress and Bit Packer

This block turns a stream of polynomial coefficients into the byte image of a lattice ciphertext. Each coefficient arrives on a valid/ready stream as a 12-bit value already reduced modulo 3329. The block rounds it down to a code of `d` bits, where `d` is chosen per run, and appends that code to a little-endian bit stream. Each complete byte is written to a ciphertext byte buffer at a running address.

A run begins with a one-cycle `start`. At that point the block captures the width, the first byte address and the number of coefficients. It accepts exactly that many coefficients. It then pulses `done` after the last byte has been written. A full ciphertext takes two runs. The first run packs the u polynomials from byte 0 at the wider width. The second run packs the v polynomial at the narrower width and starts at the byte right after the first region. The widths are 10 and 4 for the two smaller parameter sets, and 11 and 5 for the largest. The regions total 768, 1088 or 1568 bytes.

Top module: `coeff_pack_top`

## Requirements
- R1: After reset, `byteWe`, `done` and `coeffReady` are all low.
- R2: Each accepted coefficient x becomes the code round(x·2^d / 3329) mod 2^d. Ties round upward. For example, x=3328 at d=4 gives 0, and x=3328 at d=11 gives 2047.
- R3: Codes are concatenated least significant bit first. Bit 0 of the first code of a run is bit 0 of the first byte written, and each later code starts at the next free bit.
- R4: Any width from 4 to 11 packs correctly, including widths whose codes cross one or two byte boundaries. The internal bit holding never exceeds d+7 bits for the maximum d.
- R5: Bytes of a run are written to strictly consecutive addresses, starting at the `baseAddr` captured at `start`. Nothing outside that range is written.
- R6: `byteWe` pulses once per completed byte and at no other time, so a run writes exactly `coeffCount`·d/8 bytes. `coeffCount`·d must be a multiple of 8.
- R7: `coeffReady` is low while the block is idle. It is also low while 8 or more bits wait to be written.
- R8: `done` is high for exactly one cycle. It rises in the cycle right after the `byteWe` pulse that writes the final byte.
- R9: A `start` raised while a run is in progress is ignored.
- R10: `widthSel`, `baseAddr` and `coeffCount` are sampled only when a run starts. Changes during a run have no effect on it.
- R11: Two runs, u at width du from byte 0 and then v at width dv from the byte after the u region, produce one contiguous ciphertext. With du=11, dv=5 and 1024+256 coefficients, the ciphertext ends at byte 1567.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| widthSel | input | 4 | Code width d, 4 to 11 |
| baseAddr | input | 11 | Byte address of the first byte of the run |
| coeffCount | input | 11 | Number of coefficients in the run |
| coeffValid | input | 1 | Coefficient stream valid |
| coeffData | input | 12 | Coefficient, reduced mod 3329 |
| coeffReady | output | 1 | Coefficient stream ready |
| byteWe | output | 1 | Byte write strobe |
| byteAddr | output | 11 | Byte write address |
| byteData | output | 8 | Byte write data |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A coefficient accepted at a clock edge is merged into the bit holding at that same edge. A byte that the holding has completed is strobed on `byteWe` one edge later. `done` follows the final strobe by exactly one more edge. The bench therefore drives at falling edges and counts a transfer when valid and ready are both high at that falling edge. It records every `byteWe` seen at a falling edge into a shadow byte array, and it checks `done` against the strobe seen one falling edge earlier. The whole run is then compared with a bench-side model that uses integer division and a bit-serial LSB-first writer.

// File: rtl/cpack_pkg.sv
package cpack_pkg;
  localparam int unsigned MODULUS = 3329;
  localparam int unsigned COEFF_W = 12;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;   // empty the bit holding at run start
    logic accept;  // merge the current coefficient code
    logic emit;    // move the low byte out
  } cpackStrobe_t;
endpackage

// File: rtl/cpack_compress.sv
module cpack_compress
  import cpack_pkg::*;
#(
  parameter int unsigned MAX_D = 11,
  parameter int unsigned DW    = 4
) (
  input  logic [COEFF_W-1:0] coeff,
  input  logic [DW-1:0]      width,
  output logic [MAX_D-1:0]   code
);
  // round(x*2^d/q) = floor((x*2^d + (q-1)/2 + 1/2) / q); with odd q this is
  // floor((x<<d) + q/2) / q computed as a multiply by a ceiling reciprocal.
  localparam int unsigned NUM_W   = COEFF_W + MAX_D;
  localparam int unsigned SHIFT   = NUM_W + $clog2(MODULUS);
  localparam int unsigned RECIP_W = SHIFT - $clog2(MODULUS) + 2;
  localparam int unsigned PROD_W  = NUM_W + RECIP_W;
  localparam logic [RECIP_W-1:0] RECIP =
    RECIP_W'(((64'd1 << SHIFT) + 64'(MODULUS) - 64'd1) / 64'(MODULUS));
  localparam logic [NUM_W-1:0] HALF_Q = NUM_W'(MODULUS / 2);

  logic [NUM_W-1:0]  scaled;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [MAX_D-1:0]  mask;

  always_comb begin
    scaled = (NUM_W'(coeff) << width) + HALF_Q;
    prod   = PROD_W'(scaled) * PROD_W'(RECIP);
    quot   = prod >> SHIFT;
    mask   = (MAX_D'(1) << width) - MAX_D'(1);
    code   = quot[MAX_D-1:0] & mask;
  end
endmodule

// File: rtl/cpack_datapath.sv
module cpack_datapath
  import cpack_pkg::*;
#(
  parameter int unsigned MAX_D  = 11,
  parameter int unsigned DW     = 4,
  parameter int unsigned FILL_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  cpackStrobe_t       strobe,
  input  logic [DW-1:0]      width,
  input  logic [COEFF_W-1:0] coeffData,
  output logic [FILL_W-1:0]  accFill,
  output logic [7:0]         byteData
);
  localparam int unsigned ACC_W = MAX_D + 8;

  logic [MAX_D-1:0] code;
  logic [ACC_W-1:0] accBits;

  cpack_compress #(.MAX_D(MAX_D), .DW(DW)) compress_i (
    .coeff(coeffData),
    .width(width),
    .code (code)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accBits  <= '0;
      accFill  <= '0;
      byteData <= '0;
    end else if (strobe.clear) begin
      accBits <= '0;
      accFill <= '0;
    end else if (strobe.emit) begin
      byteData <= accBits[7:0];
      accBits  <= accBits >> 8;
      accFill  <= accFill - FILL_W'(8);
    end else if (strobe.accept) begin
      accBits <= accBits | (ACC_W'(code) << accFill);
      accFill <= accFill + FILL_W'(width);
    end
  end
endmodule

// File: rtl/cpack_ctrl.sv
module cpack_ctrl
  import cpack_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned COUNT_W = 11,
  parameter int unsigned DW      = 4,
  parameter int unsigned FILL_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DW-1:0]      widthSel,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [COUNT_W-1:0] coeffCount,
  input  logic               coeffValid,
  input  logic [FILL_W-1:0]  accFill,
  output logic               coeffReady,
  output logic               busy,
  output logic [DW-1:0]      width,
  output cpackStrobe_t       strobe,
  output logic               byteWe,
  output logic [ADDR_W-1:0]  byteAddr,
  output logic               done
);
  logic [COUNT_W-1:0] remaining;
  logic [ADDR_W-1:0]  nextAddr;
  logic               launch;
  logic               pending;
  logic               finish;

  always_comb begin
    launch        = start && !busy;
    pending       = accFill >= FILL_W'(8);
    coeffReady    = busy && (remaining != '0) && !pending;
    finish        = busy && (remaining == '0) && (accFill == '0);
    strobe.clear  = launch;
    strobe.emit   = busy && pending;
    strobe.accept = coeffValid && coeffReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      width     <= '0;
      remaining <= '0;
      nextAddr  <= '0;
      byteAddr  <= '0;
      byteWe    <= 1'b0;
      done      <= 1'b0;
    end else begin
      byteWe <= strobe.emit;
      done   <= finish;
      if (launch) begin
        busy      <= 1'b1;
        width     <= widthSel;
        remaining <= coeffCount;
        nextAddr  <= baseAddr;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (strobe.accept) remaining <= remaining - COUNT_W'(1);
      if (strobe.emit) begin
        byteAddr <= nextAddr;
        nextAddr <= nextAddr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/coeff_pack_top.sv
module coeff_pack_top
  import cpack_pkg::*;
#(
  parameter int unsigned MAX_D   = 11,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned COUNT_W = 11,
  localparam int unsigned DW     = $clog2(MAX_D + 1),
  localparam int unsigned FILL_W = $clog2(MAX_D + 8 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DW-1:0]      widthSel,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [COUNT_W-1:0] coeffCount,
  input  logic               coeffValid,
  input  logic [COEFF_W-1:0] coeffData,
  output logic               coeffReady,
  output logic               byteWe,
  output logic [ADDR_W-1:0]  byteAddr,
  output logic [7:0]         byteData,
  output logic               done
);
  cpackStrobe_t      strobe;
  logic [FILL_W-1:0] accFill;
  logic [DW-1:0]     width;
  logic              busy;

  cpack_ctrl #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .DW(DW), .FILL_W(FILL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .widthSel(widthSel),
    .baseAddr(baseAddr), .coeffCount(coeffCount), .coeffValid(coeffValid),
    .accFill(accFill), .coeffReady(coeffReady), .busy(busy), .width(width),
    .strobe(strobe), .byteWe(byteWe), .byteAddr(byteAddr), .done(done)
  );

  cpack_datapath #(.MAX_D(MAX_D), .DW(DW), .FILL_W(FILL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .width(width),
    .coeffData(coeffData), .accFill(accFill), .byteData(byteData)
  );
endmodule

// File: rtl/coeff_pack_checker.sv
module coeff_pack_checker #(
  parameter int unsigned MAX_D  = 11,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FILL_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              coeffReady,
  input logic              byteWe,
  input logic [ADDR_W-1:0] byteAddr,
  input logic              done,
  input logic [FILL_W-1:0] accFill
);
  logic              seenByte;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenByte <= 1'b0;
      prevAddr <= '0;
    end else begin
      if (start && !busy) seenByte <= 1'b0;
      if (byteWe) begin
        seenByte <= 1'b1;
        prevAddr <= byteAddr;
      end
    end
  end

  // R5: consecutive byte addresses within a run
  always_ff @(posedge clk) begin
    if (rstN && byteWe && seenByte)
      p_addr_step_r5: assert (byteAddr == prevAddr + ADDR_W'(1));
  end

  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    coeffReady |-> (busy && accFill < FILL_W'(8)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    accFill <= FILL_W'(MAX_D + 7));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !byteWe));

  p_write_in_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteWe |-> busy);
endmodule

bind coeff_pack_top coeff_pack_checker #(.MAX_D(MAX_D), .ADDR_W(ADDR_W), .FILL_W(FILL_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .coeffReady(coeffReady),
  .byteWe(byteWe), .byteAddr(byteAddr), .done(done), .accFill(accFill)
);

// File: tb/coeff_pack_top_tb_top.sv
module coeff_pack_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3329;
  localparam int MEM = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  widthSel = 4'd4;
  logic [10:0] baseAddr = '0;
  logic [10:0] coeffCount = '0;
  logic        coeffValid = 1'b0;
  logic [11:0] coeffData = '0;
  logic        coeffReady, byteWe, done;
  logic [10:0] byteAddr;
  logic [7:0]  byteData;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  int   coeffs [0:1023];
  logic [7:0] expMem [0:MEM-1];
  logic [7:0] gotMem [0:MEM-1];
  bit   written [0:MEM-1];
  int   nWrites, doneCount, doneBad;
  bit   prevWe;
  bit   usePreset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coeff_pack_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .widthSel(widthSel),
    .baseAddr(baseAddr), .coeffCount(coeffCount), .coeffValid(coeffValid),
    .coeffData(coeffData), .coeffReady(coeffReady), .byteWe(byteWe),
    .byteAddr(byteAddr), .byteData(byteData), .done(done)
  );

  // monitor away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (byteWe) begin
        gotMem[byteAddr] = byteData;
        written[byteAddr] = 1'b1;
        nWrites++;
      end
      if (done) begin
        doneCount++;
        if (!prevWe) doneBad++;
      end
      prevWe = byteWe;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int modelCode(input int x, input int d);
    int n = (x << d) * 2 + Q;
    return (n / (2 * Q)) % (1 << d);
  endfunction

  task automatic buildExpected(input int d, input int base, input int cnt);
    int bitPos = base * 8;
    for (int i = 0; i < MEM; i++) expMem[i] = 8'h00;
    for (int i = 0; i < cnt; i++) begin
      int c = modelCode(coeffs[i], d);
      for (int b = 0; b < d; b++) begin
        expMem[bitPos / 8][bitPos % 8] = c[b];
        bitPos++;
      end
    end
  endtask

  task automatic runPack(input int d, input int base, input int cnt, input int gapPct,
                         input bit midStart, input bit midWidth, input string req);
    int i = 0;
    int nBytes = cnt * d / 8;
    int bad = 0;
    int stray = 0;
    int guard = 0;
    for (int k = 0; k < MEM; k++) written[k] = 1'b0;
    nWrites = 0; doneCount = 0; doneBad = 0;
    if (!usePreset) begin
      for (int k = 0; k < cnt; k++) coeffs[k] = $urandom % Q;
      if (cnt > 3) begin
        coeffs[0] = 3328; coeffs[1] = 1664; coeffs[2] = 1665; coeffs[3] = 0;
      end
    end
    buildExpected(d, base, cnt);
    @(negedge clk);
    widthSel = 4'(d); baseAddr = 11'(base); coeffCount = 11'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (i < cnt && guard < 20000) begin
      coeffValid = (($urandom % 100) >= gapPct);
      coeffData  = 12'(coeffs[i]);
      start = midStart && (i == cnt / 2);           // R9 stimulus
      if (midStart && i == cnt / 2) baseAddr = 11'(base + 5);
      if (midWidth) begin                          // R10 stimulus
        widthSel = 4'(d ^ 1); coeffCount = 11'(cnt + 8);
      end
      if (coeffValid && coeffReady) i++;
      guard++;
      @(negedge clk);
    end
    coeffValid = 1'b0; start = 1'b0;
    guard = 0;
    while (doneCount == 0 && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < MEM; k++) begin
      if (k >= base && k < base + nBytes) begin
        if (!written[k] || gotMem[k] !== expMem[k]) begin
          if (bad < 4)
            $display("  byte %0d got=%02h exp=%02h (%s)", k, gotMem[k], expMem[k], req);
          bad++;
        end
      end else if (written[k]) stray++;
    end
    check(bad == 0, req, $sformatf("R3/R4 packed bytes d=%0d mismatches", d), bad, 0);
    check(nWrites == nBytes, "R6", "byte write count", nWrites, nBytes);
    check(stray == 0, "R5", "writes outside region", stray, 0);
    check(doneCount == 1, "R8", "done pulses", doneCount, 1);
    check(doneBad == 0, "R8", "done not right after last write", doneBad, 0);
    check(coeffReady == 1'b0, "R7", "ready after run", int'(coeffReady), 0);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(byteWe == 1'b0, "R1", "byteWe in reset", int'(byteWe), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(coeffReady == 1'b0, "R1", "ready in reset", int'(coeffReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(byteWe == 1'b0 && done == 1'b0, "R1", "outputs after reset", int'(byteWe), 0);

    // R7 idle: valid offered without start is never accepted
    nWrites = 0;
    coeffValid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      check(coeffReady == 1'b0, "R7", "ready while idle", int'(coeffReady), 0);
      @(negedge clk);
    end
    coeffValid = 1'b0;
    check(nWrites == 0, "R7", "writes while idle", nWrites, 0);

    // R2/R3: explicit codes. 208->1, 1665->8 at d=4 -> byte 0x81
    usePreset = 1;
    coeffs[0] = 208; coeffs[1] = 1665;
    runPack(4, 3, 2, 0, 0, 0, "R2");
    check(gotMem[3] == 8'h81, "R3", "first byte LSB-first", int'(gotMem[3]), 'h81);
    // R2: 3328 at d=4 wraps to 0
    coeffs[0] = 3328; coeffs[1] = 3328;
    runPack(4, 0, 2, 0, 0, 0, "R2");
    check(gotMem[0] == 8'h00, "R2", "3328 at d=4", int'(gotMem[0]), 0);
    // R2: 3328 at d=11 -> 2047, eight codes fill 11 bytes of ones
    for (int k = 0; k < 8; k++) coeffs[k] = 3328;
    runPack(11, 20, 8, 0, 0, 0, "R2");
    check(gotMem[20] == 8'hFF && gotMem[30] == 8'hFF, "R2", "3328 at d=11",
          int'(gotMem[30]), 'hFF);
    usePreset = 0;

    // R4: every width 4..11, random gaps and bases
    for (int d = 4; d <= 11; d++)
      runPack(d, 17 * d, 64, 30, 0, 0, "R4");

    // R9: start during a run is ignored
    runPack(11, 100, 64, 20, 1, 0, "R9");
    // R10: width/count/base changes during a run are ignored
    runPack(10, 40, 64, 10, 0, 1, "R10");

    // R11: full ciphertexts, u region then v region
    runPack(11, 0, 1024, 0, 0, 0, "R11");
    runPack(5, 1408, 256, 0, 0, 0, "R11");
    check(written[1567] && !written[1568], "R11", "K=4 ciphertext end byte",
          int'(written[1567]), 1);
    runPack(10, 0, 512, 5, 0, 0, "R11");
    runPack(4, 640, 256, 5, 0, 0, "R11");
    check(written[767] && !written[768], "R11", "K=2 ciphertext end byte",
          int'(written[767]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule